// File: doc/BRIEF.md
# Banked Memory Map Address Decoder

This block sits between an 8-bit CPU and the memories of its system. It takes a 16-bit CPU address, works out which region the address falls in, and drives a chip select and a local offset to that region's memory. Reads are combinational: the decoder returns the byte from the selected source on the same cycle, or the open-bus value 0xFF when nothing answers. Writes take effect on the rising clock edge while the write strobe is high.

Most targets are outside the block: ROM, video RAM, external RAM, work RAM, sprite attribute memory and the I/O registers all connect through their own select, write strobe and offset ports, and all share the CPU write data. The block holds four things of its own. These are the switchable work-RAM bank register, the high-RAM array, the interrupt-enable byte and a small file of timekeeper registers. Any write that lands in the ROM window changes no memory. It is passed to a bank-controller write port instead, and the current switchable ROM bank number comes back in as an input.

Top module: `mem_map_decoder`

## Requirements
- R1: A read in 0x0000-0x3FFF asserts `rom_cs` with `rom_addr` = {0, addr[13:0]}. A read in 0x4000-0x7FFF asserts `rom_cs` with `rom_addr` = {`rom_bank`, addr[13:0]}. In both cases `cpu_rdata` = `rom_rdata`.
- R2: A write in 0x0000-0x7FFF asserts `mbc_wr` with `mbc_addr` = addr[14:0]. It asserts no other write strobe, and `rom_cs` stays low.
- R3: 0x8000-0x9FFF asserts `vram_cs` with `vram_addr` = addr[12:0]. Reads return `vram_rdata`, and writes assert `vram_we`.
- R4: In 0xA000-0xBFFF the timekeeper has priority when `rtc_en` is high. The register chosen by `rtc_sel` is read or written, and `xram_cs` stays low. Otherwise, when `ram_en` is high, external RAM is used, with `xram_addr` = addr[12:0]. Otherwise reads give 0xFF and writes change nothing.
- R5: 0xC000-0xCFFF and its mirror 0xE000-0xEFFF drive `wram_addr` = {3'd0, addr[11:0]}. 0xD000-0xDFFF and its mirror 0xF000-0xFDFF drive `wram_addr` = {bank, addr[11:0]}. In all four windows `wram_cs` is high.
- R6: A write to 0xFF70 loads the work-RAM bank register from data bits [2:0], and a value of 0 selects bank 1. The register resets to bank 1. Reading 0xFF70 returns {5'b11111, bank}, and the access is not forwarded to the I/O port.
- R7: 0xFE00-0xFE9F drives `oam_addr` = addr[7:0]. `oam_cs` and `oam_we` assert only when `video_mode` is 0 or 1, and reads in modes 2 and 3 return 0xFF.
- R8: 0xFEA0-0xFEFF reads as 0xFF. A write there asserts no strobe.
- R9: 0xFF00-0xFF7F (except 0xFF70) asserts `io_cs` with `io_addr` = addr[6:0]. Reads return `io_rdata`.
- R10: 0xFF80-0xFFFE is internal high RAM, which stores and returns bytes. 0xFFFF is an internal interrupt-enable byte. Both reset to 0x00, and so do the timekeeper registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data, shared by all targets |
| cpu_wr | input | 1 | Write strobe |
| cpu_rdata | output | 8 | Read data for the current address |
| video_mode | input | 2 | Current video mode (0-3) |
| rom_bank | input | 8 | Switchable ROM bank from the bank controller |
| rtc_en | input | 1 | Timekeeper access enabled |
| ram_en | input | 1 | External RAM access enabled |
| rtc_sel | input | 3 | Selected timekeeper register |
| rom_cs | output | 1 | ROM read select |
| rom_addr | output | 22 | ROM byte address {bank, offset} |
| rom_rdata | input | 8 | ROM read data |
| mbc_wr | output | 1 | Bank-controller write strobe |
| mbc_addr | output | 15 | Bank-controller write address |
| vram_cs | output | 1 | Video RAM select |
| vram_we | output | 1 | Video RAM write strobe |
| vram_addr | output | 13 | Video RAM offset |
| vram_rdata | input | 8 | Video RAM read data |
| xram_cs | output | 1 | External RAM select |
| xram_we | output | 1 | External RAM write strobe |
| xram_addr | output | 13 | External RAM offset |
| xram_rdata | input | 8 | External RAM read data |
| wram_cs | output | 1 | Work RAM select |
| wram_we | output | 1 | Work RAM write strobe |
| wram_addr | output | 15 | Work RAM address {bank, offset} |
| wram_rdata | input | 8 | Work RAM read data |
| oam_cs | output | 1 | Sprite memory select |
| oam_we | output | 1 | Sprite memory write strobe |
| oam_addr | output | 8 | Sprite memory offset |
| oam_rdata | input | 8 | Sprite memory read data |
| io_cs | output | 1 | I/O register select |
| io_we | output | 1 | I/O register write strobe |
| io_addr | output | 7 | I/O register offset |
| io_rdata | input | 8 | I/O register read data |

## Verification
The bench walks every region boundary address, so it catches a decoder whose comparisons are off by one. Such a decoder would send 0xFE9F into the hole or 0xFFFE to the interrupt-enable byte. It writes each bank value from 0 to 7 and checks both work-RAM windows and their mirrors for each one. A design that let bank 0 through would alias the switchable window onto bank 0, and a mirror decoded on the wrong bit would land in the wrong bank. It also checks the timekeeper priority with both enables high and the sprite-memory gate in all four video modes. A reversed priority or a gate on the wrong modes would show up as stray data or a stray write strobe. Finally, it confirms that a write into ROM raises only the bank-controller strobe, which catches any design that also treats such a write as a memory write.

// File: rtl/mmap_pkg.sv
// Shared types and fixed boundaries for the memory map decoder.
package mmap_pkg;
    typedef enum logic [3:0] {
        RG_ROM0, RG_ROMX, RG_VRAM, RG_XRAM, RG_WRAM0, RG_WRAMX,
        RG_OAM, RG_HOLE, RG_IO, RG_HRAM, RG_IE
    } region_e;

    localparam logic [15:0] OAM_BASE  = 16'hFE00;
    localparam logic [15:0] HOLE_BASE = 16'hFEA0;
    localparam logic [15:0] IO_BASE   = 16'hFF00;
    localparam logic [15:0] HRAM_BASE = 16'hFF80;
    localparam logic [15:0] IE_ADDR   = 16'hFFFF;
    localparam logic [7:0]  OPEN_BUS  = 8'hFF;
endpackage

// File: rtl/mmap_region_decode.sv
// Region decoder: classifies a 16-bit address into one map region.
// Assumes: purely combinational; upper nibbles pick the coarse window,
// the 0xF000 page is split by full comparisons against fixed bases.
module mmap_region_decode
    import mmap_pkg::*;
(
    input  logic [15:0] addr,
    output region_e     region
);
    // Purpose: map the address to a region code.
    always_comb begin
        if (addr[15:14] == 2'b00)         region = RG_ROM0;
        else if (addr[15:14] == 2'b01)    region = RG_ROMX;
        else if (addr[15:13] == 3'b100)   region = RG_VRAM;
        else if (addr[15:13] == 3'b101)   region = RG_XRAM;
        else if (addr < OAM_BASE)         region = addr[12] ? RG_WRAMX : RG_WRAM0;
        else if (addr < HOLE_BASE)        region = RG_OAM;
        else if (addr < IO_BASE)          region = RG_HOLE;
        else if (addr < HRAM_BASE)        region = RG_IO;
        else if (addr < IE_ADDR)          region = RG_HRAM;
        else                              region = RG_IE;
    end
endmodule

// File: rtl/mmap_wram_bank.sv
// Work-RAM bank register. Keeps BANK_W low bits of the written value;
// a zero selects bank 1. Assumes wr_en is already qualified by address.
module mmap_wram_bank #(
    parameter int BANK_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BANK_W-1:0] wdata,
    output logic [BANK_W-1:0] bank
);
    localparam logic [BANK_W-1:0] BANK_ONE = BANK_W'(1);

    // Purpose: hold the selected bank, remapping zero to one.
    always_ff @(posedge clk) begin
        if (!rst_n)      bank <= BANK_ONE;
        else if (wr_en)  bank <= (wdata == '0) ? BANK_ONE : wdata;
    end

    // R6: the selected bank is never zero
    assert_bank_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bank != '0);
    // R6: a write with nonzero data is taken as is
    assert_bank_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdata != '0) |=> bank == $past(wdata));
    // R6: without a write the bank holds
    assert_bank_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(bank));
endmodule

// File: rtl/mmap_hram.sv
// High RAM and interrupt-enable byte. HRAM has HRAM_N bytes indexed by
// the low address bits; index values at or above HRAM_N are never written.
module mmap_hram #(
    parameter int HRAM_N = 127,
    parameter int IDX_W  = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hram_we,
    input  logic             ie_we,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       wdata,
    output logic [7:0]       hram_q,
    output logic [7:0]       ie_q
);
    logic [7:0] mem [HRAM_N];
    logic       idx_ok;

    assign idx_ok = (int'(idx) < HRAM_N);

    // Purpose: store high-RAM bytes, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < HRAM_N; i++) mem[i] <= 8'h00;
        end else if (hram_we && idx_ok) begin
            mem[idx] <= wdata;
        end
    end

    // Purpose: store the interrupt-enable byte.
    always_ff @(posedge clk) begin
        if (!rst_n)      ie_q <= 8'h00;
        else if (ie_we)  ie_q <= wdata;
    end

    // Purpose: combinational read of the addressed byte.
    always_comb hram_q = idx_ok ? mem[idx] : 8'hFF;

    // R10: the enable byte changes only when written
    assert_ie_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ie_we |=> $stable(ie_q));
    // R10: a high-RAM write reads back next cycle at the same index
    assert_hram_store_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hram_we && idx_ok) ##1 (idx == $past(idx)) |-> hram_q == $past(wdata));
endmodule

// File: rtl/mmap_rtc_file.sv
// Timekeeper register file: NREG bytes chosen by sel. A selector beyond
// the file reads 0xFF and drops writes.
module mmap_rtc_file #(
    parameter int NREG  = 5,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SEL_W-1:0] sel,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata
);
    logic [7:0] regs [NREG];
    logic       sel_ok;

    assign sel_ok = (int'(sel) < NREG);

    // Purpose: hold the timekeeper bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= 8'h00;
        end else if (we && sel_ok) begin
            regs[sel] <= wdata;
        end
    end

    // Purpose: return the selected byte.
    always_comb rdata = sel_ok ? regs[sel] : 8'hFF;
endmodule

// File: rtl/mem_map_decoder.sv
// Banked memory map decoder. Classifies the CPU address, drives selects,
// strobes and offsets to external targets, owns the work-RAM bank
// register, high RAM, interrupt-enable byte and timekeeper bytes, and
// muxes read data combinationally. Assumes one access per cycle and that
// cpu_wr is a single-cycle-qualified strobe sampled on the rising edge.
module mem_map_decoder
    import mmap_pkg::*;
#(
    parameter int          ROM_BANK_W = 8,
    parameter int          WBANK_W    = 3,
    parameter int          RTC_NREG   = 5,
    parameter int          RTC_SEL_W  = 3,
    parameter logic [6:0]  WBANK_OFS  = 7'h70,
    localparam int         ROM_OFS_W  = 14,
    localparam int         ROM_AW     = ROM_BANK_W + ROM_OFS_W,
    localparam int         WRAM_OFS_W = 12,
    localparam int         WRAM_AW    = WBANK_W + WRAM_OFS_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [15:0]          cpu_addr,
    input  logic [7:0]           cpu_wdata,
    input  logic                 cpu_wr,
    output logic [7:0]           cpu_rdata,
    input  logic [1:0]           video_mode,
    input  logic [ROM_BANK_W-1:0] rom_bank,
    input  logic                 rtc_en,
    input  logic                 ram_en,
    input  logic [RTC_SEL_W-1:0] rtc_sel,
    output logic                 rom_cs,
    output logic [ROM_AW-1:0]    rom_addr,
    input  logic [7:0]           rom_rdata,
    output logic                 mbc_wr,
    output logic [14:0]          mbc_addr,
    output logic                 vram_cs,
    output logic                 vram_we,
    output logic [12:0]          vram_addr,
    input  logic [7:0]           vram_rdata,
    output logic                 xram_cs,
    output logic                 xram_we,
    output logic [12:0]          xram_addr,
    input  logic [7:0]           xram_rdata,
    output logic                 wram_cs,
    output logic                 wram_we,
    output logic [WRAM_AW-1:0]   wram_addr,
    input  logic [7:0]           wram_rdata,
    output logic                 oam_cs,
    output logic                 oam_we,
    output logic [7:0]           oam_addr,
    input  logic [7:0]           oam_rdata,
    output logic                 io_cs,
    output logic                 io_we,
    output logic [6:0]           io_addr,
    input  logic [7:0]           io_rdata
);
    localparam int BANK_PAD = 8 - WBANK_W;

    region_e              region;
    logic                 is_rom, is_wram, is_wbank, oam_open;
    logic [WBANK_W-1:0]   wbank;
    logic [ROM_BANK_W-1:0] rom_page;
    logic [7:0]           hram_q, ie_q, rtc_q;
    logic                 rtc_we;

    mmap_region_decode u_dec (
        .addr   (cpu_addr),
        .region (region)
    );

    // Purpose: region qualifiers shared by selects and the read mux.
    always_comb begin
        is_rom   = (region == RG_ROM0) || (region == RG_ROMX);
        is_wram  = (region == RG_WRAM0) || (region == RG_WRAMX);
        is_wbank = (region == RG_IO) && (cpu_addr[6:0] == WBANK_OFS);
        oam_open = (video_mode < 2'd2);
        rom_page = (region == RG_ROMX) ? rom_bank : '0;
    end

    // Purpose: chip selects, offsets and write strobes toward targets.
    always_comb begin
        rom_cs    = is_rom && !cpu_wr;
        rom_addr  = {rom_page, cpu_addr[ROM_OFS_W-1:0]};
        mbc_wr    = is_rom && cpu_wr;
        mbc_addr  = cpu_addr[14:0];
        vram_cs   = (region == RG_VRAM);
        vram_we   = vram_cs && cpu_wr;
        vram_addr = cpu_addr[12:0];
        xram_cs   = (region == RG_XRAM) && !rtc_en && ram_en;
        xram_we   = xram_cs && cpu_wr;
        xram_addr = cpu_addr[12:0];
        rtc_we    = (region == RG_XRAM) && rtc_en && cpu_wr;
        wram_cs   = is_wram;
        wram_we   = is_wram && cpu_wr;
        wram_addr = {(region == RG_WRAMX) ? wbank : {WBANK_W{1'b0}},
                     cpu_addr[WRAM_OFS_W-1:0]};
        oam_cs    = (region == RG_OAM) && oam_open;
        oam_we    = oam_cs && cpu_wr;
        oam_addr  = cpu_addr[7:0];
        io_cs     = (region == RG_IO) && !is_wbank;
        io_we     = io_cs && cpu_wr;
        io_addr   = cpu_addr[6:0];
    end

    mmap_wram_bank #(.BANK_W(WBANK_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (is_wbank && cpu_wr),
        .wdata (cpu_wdata[WBANK_W-1:0]),
        .bank  (wbank)
    );

    mmap_hram #(.HRAM_N(127), .IDX_W(7)) u_hram (
        .clk     (clk),
        .rst_n   (rst_n),
        .hram_we ((region == RG_HRAM) && cpu_wr),
        .ie_we   ((region == RG_IE) && cpu_wr),
        .idx     (cpu_addr[6:0]),
        .wdata   (cpu_wdata),
        .hram_q  (hram_q),
        .ie_q    (ie_q)
    );

    mmap_rtc_file #(.NREG(RTC_NREG), .SEL_W(RTC_SEL_W)) u_rtc (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rtc_we),
        .sel   (rtc_sel),
        .wdata (cpu_wdata),
        .rdata (rtc_q)
    );

    // Purpose: select read data for the current address.
    always_comb begin
        unique case (region)
            RG_ROM0, RG_ROMX:   cpu_rdata = rom_rdata;
            RG_VRAM:            cpu_rdata = vram_rdata;
            RG_XRAM:            cpu_rdata = rtc_en ? rtc_q : (ram_en ? xram_rdata : OPEN_BUS);
            RG_WRAM0, RG_WRAMX: cpu_rdata = wram_rdata;
            RG_OAM:             cpu_rdata = oam_open ? oam_rdata : OPEN_BUS;
            RG_IO:              cpu_rdata = is_wbank ? {{BANK_PAD{1'b1}}, wbank} : io_rdata;
            RG_HRAM:            cpu_rdata = hram_q;
            RG_IE:              cpu_rdata = ie_q;
            default:            cpu_rdata = OPEN_BUS;
        endcase
    end

    // R2: a bank-controller write raises no memory write strobe
    assert_rom_write_isolated_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mbc_wr |-> !(vram_we || xram_we || wram_we || oam_we || io_we || rom_cs));
    // R4: external RAM is never selected while the timekeeper is enabled
    assert_xram_yields_R4: assert property (@(posedge clk) disable iff (!rst_n)
        xram_cs |-> !rtc_en);
    // R7: sprite memory is never written in modes 2 or 3
    assert_oam_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        oam_we |-> video_mode < 2'd2);
    // R7: blocked sprite memory reads give open bus
    assert_oam_open_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr >= OAM_BASE && cpu_addr < HOLE_BASE && video_mode >= 2'd2) |-> cpu_rdata == 8'hFF);
    // R8: the hole reads open bus and raises no select
    assert_hole_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr >= HOLE_BASE && cpu_addr < IO_BASE) |->
        (cpu_rdata == 8'hFF && !oam_cs && !io_cs && !wram_cs));
    // R5: at most one target select at a time
    assert_one_select_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rom_cs, vram_cs, xram_cs, wram_cs, oam_cs, io_cs}));
endmodule

// File: tb/sim_mem_map_decoder.sv
module sim_mem_map_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_wdata = 8'h00;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_rdata;
    logic [1:0]  video_mode = 2'd0;
    logic [7:0]  rom_bank = 8'd1;
    logic        rtc_en = 1'b0, ram_en = 1'b0;
    logic [2:0]  rtc_sel = 3'd0;
    logic        rom_cs, mbc_wr, vram_cs, vram_we, xram_cs, xram_we;
    logic        wram_cs, wram_we, oam_cs, oam_we, io_cs, io_we;
    logic [21:0] rom_addr;
    logic [14:0] mbc_addr, wram_addr;
    logic [12:0] vram_addr, xram_addr;
    logic [7:0]  oam_addr;
    logic [6:0]  io_addr;
    localparam logic [7:0] D_ROM = 8'h11, D_VRAM = 8'h22, D_XRAM = 8'h33,
                           D_WRAM = 8'h44, D_OAM = 8'h55, D_IO = 8'h66;
    int checks = 0, fails = 0;

    always #10 clk = ~clk;

    mem_map_decoder u0 (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata), .video_mode(video_mode),
        .rom_bank(rom_bank), .rtc_en(rtc_en), .ram_en(ram_en), .rtc_sel(rtc_sel),
        .rom_cs(rom_cs), .rom_addr(rom_addr), .rom_rdata(D_ROM),
        .mbc_wr(mbc_wr), .mbc_addr(mbc_addr),
        .vram_cs(vram_cs), .vram_we(vram_we), .vram_addr(vram_addr), .vram_rdata(D_VRAM),
        .xram_cs(xram_cs), .xram_we(xram_we), .xram_addr(xram_addr), .xram_rdata(D_XRAM),
        .wram_cs(wram_cs), .wram_we(wram_we), .wram_addr(wram_addr), .wram_rdata(D_WRAM),
        .oam_cs(oam_cs), .oam_we(oam_we), .oam_addr(oam_addr), .oam_rdata(D_OAM),
        .io_cs(io_cs), .io_we(io_we), .io_addr(io_addr), .io_rdata(D_IO)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Present a read address and let the combinational path settle.
    task automatic rd(input logic [15:0] a);
        @(negedge clk);
        cpu_addr = a; cpu_wr = 1'b0;
        #1;
    endtask

    // Hold a write for one rising edge; strobes are visible after #1.
    task automatic wr_begin(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        #1;
    endtask

    task automatic wr_end();
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    function automatic logic [5:0] strobes();
        return {mbc_wr, vram_we, xram_we, wram_we, oam_we, io_we};
    endfunction

    task automatic t_reset();
        rd(16'hFF70); chk("R6 reset bank", cpu_rdata, 8'hF9);
        rd(16'hFFFF); chk("R10 reset IE", cpu_rdata, 8'h00);
        rd(16'hFF80); chk("R10 reset HRAM low", cpu_rdata, 8'h00);
        rd(16'hFFFE); chk("R10 reset HRAM high", cpu_rdata, 8'h00);
        rtc_en = 1'b1; rtc_sel = 3'd4;
        rd(16'hA000); chk("R10 reset timekeeper", cpu_rdata, 8'h00);
        rtc_en = 1'b0;
    endtask

    task automatic t_rom();
        rom_bank = 8'h05;
        rd(16'h0000); chk("R1 rom0 low", {rom_cs, rom_addr}, {1'b1, 22'h000000});
        chk("R1 rom data", cpu_rdata, D_ROM);
        rd(16'h3FFF); chk("R1 rom0 high", {rom_cs, rom_addr}, {1'b1, 22'h003FFF});
        rd(16'h4000); chk("R1 romx low", {rom_cs, rom_addr}, {1'b1, 8'h05, 14'h0000});
        rd(16'h7FFF); chk("R1 romx high", {rom_cs, rom_addr}, {1'b1, 8'h05, 14'h3FFF});
        rom_bank = 8'hA3;
        rd(16'h5123); chk("R1 romx bank", rom_addr, {8'hA3, 14'h1123});
        wr_begin(16'h2000, 8'h07);
        chk("R2 mbc strobe", {strobes(), rom_cs}, {6'b100000, 1'b0});
        chk("R2 mbc addr", mbc_addr, 15'h2000);
        wr_end();
        wr_begin(16'h7FFF, 8'h01);
        chk("R2 mbc high", {strobes(), mbc_addr}, {6'b100000, 15'h7FFF});
        wr_end();
    endtask

    task automatic t_vram();
        rd(16'h8000); chk("R3 vram low", {vram_cs, vram_addr, cpu_rdata}, {1'b1, 13'h0000, D_VRAM});
        rd(16'h9FFF); chk("R3 vram high", {vram_cs, vram_addr}, {1'b1, 13'h1FFF});
        rd(16'h7FFF); chk("R3 below vram", vram_cs, 1'b0);
        wr_begin(16'h8ABC, 8'h5A);
        chk("R3 vram write", {strobes(), vram_addr}, {6'b010000, 13'h0ABC});
        wr_end();
    endtask

    task automatic t_xram();
        rtc_en = 0; ram_en = 0;
        rd(16'hA000); chk("R4 none open bus", {xram_cs, cpu_rdata}, {1'b0, 8'hFF});
        wr_begin(16'hA000, 8'h12); chk("R4 none no strobe", strobes(), 6'b0); wr_end();
        ram_en = 1;
        rd(16'hBFFF); chk("R4 ram", {xram_cs, xram_addr, cpu_rdata}, {1'b1, 13'h1FFF, D_XRAM});
        wr_begin(16'hA010, 8'h34); chk("R4 ram write", strobes(), 6'b001000); wr_end();
        rtc_en = 1; rtc_sel = 3'd2;
        wr_begin(16'hA000, 8'h9C); chk("R4 rtc priority strobe", {xram_cs, strobes()}, 7'b0); wr_end();
        rd(16'hBFFF); chk("R4 rtc read", {xram_cs, cpu_rdata}, {1'b0, 8'h9C});
        rtc_sel = 3'd1;
        rd(16'hA000); chk("R4 rtc other reg", cpu_rdata, 8'h00);
        rtc_en = 0;
        rd(16'hA000); chk("R4 ram after rtc off", cpu_rdata, D_XRAM);
        ram_en = 0;
    endtask

    task automatic t_wram();
        for (int b = 0; b < 8; b++) begin
            logic [2:0] eb;
            eb = (b == 0) ? 3'd1 : 3'(b);
            wr_begin(16'hFF70, 8'(b) | 8'hF8);
            chk("R6 bank write no io", {io_cs, strobes()}, 7'b0);
            wr_end();
            rd(16'hFF70); chk("R6 bank readback", cpu_rdata, {5'b11111, eb});
            rd(16'hC000); chk("R5 bank0 low", {wram_cs, wram_addr}, {1'b1, 3'd0, 12'h000});
            rd(16'hCFFF); chk("R5 bank0 high", wram_addr, {3'd0, 12'hFFF});
            rd(16'hE000); chk("R5 mirror0 low", wram_addr, {3'd0, 12'h000});
            rd(16'hEFFF); chk("R5 mirror0 high", wram_addr, {3'd0, 12'hFFF});
            rd(16'hD000); chk("R5 banked low", {wram_cs, wram_addr, cpu_rdata}, {1'b1, eb, 12'h000, D_WRAM});
            rd(16'hDFFF); chk("R5 banked high", wram_addr, {eb, 12'hFFF});
            rd(16'hF000); chk("R5 mirrorx low", wram_addr, {eb, 12'h000});
            rd(16'hFDFF); chk("R5 mirrorx high", {wram_cs, wram_addr}, {1'b1, eb, 12'hDFF});
        end
        wr_begin(16'hD123, 8'h00); chk("R5 wram write", strobes(), 6'b000100); wr_end();
    endtask

    task automatic t_oam();
        for (int m = 0; m < 4; m++) begin
            logic open;
            open = (m < 2);
            video_mode = 2'(m);
            rd(16'hFE00); chk("R7 oam low", {oam_cs, cpu_rdata}, {open, open ? D_OAM : 8'hFF});
            rd(16'hFE9F); chk("R7 oam high", {oam_cs, oam_addr, cpu_rdata}, {open, 8'h9F, open ? D_OAM : 8'hFF});
            wr_begin(16'hFE40, 8'h77); chk("R7 oam write", strobes(), {4'b0, open, 1'b0}); wr_end();
        end
        video_mode = 2'd0;
    endtask

    task automatic t_hole();
        rd(16'hFEA0); chk("R8 hole low", {oam_cs, cpu_rdata}, {1'b0, 8'hFF});
        rd(16'hFEFF); chk("R8 hole high", {io_cs, cpu_rdata}, {1'b0, 8'hFF});
        wr_begin(16'hFEC0, 8'h01); chk("R8 hole write", strobes(), 6'b0); wr_end();
    endtask

    task automatic t_io_hram();
        rd(16'hFF00); chk("R9 io low", {io_cs, io_addr, cpu_rdata}, {1'b1, 7'h00, D_IO});
        rd(16'hFF7F); chk("R9 io high", {io_cs, io_addr}, {1'b1, 7'h7F});
        rd(16'hFF6F); chk("R9 io next to bank", {io_cs, cpu_rdata}, {1'b1, D_IO});
        wr_begin(16'hFF40, 8'h91); chk("R9 io write", {strobes(), io_addr}, {6'b000001, 7'h40}); wr_end();
        wr_begin(16'hFF80, 8'hA5); chk("R10 hram write no io", {io_cs, strobes()}, 7'b0); wr_end();
        wr_begin(16'hFFFE, 8'h3C); wr_end();
        wr_begin(16'hFFFF, 8'h1F); wr_end();
        rd(16'hFF80); chk("R10 hram low", cpu_rdata, 8'hA5);
        rd(16'hFFFE); chk("R10 hram high", cpu_rdata, 8'h3C);
        rd(16'hFFFF); chk("R10 IE", cpu_rdata, 8'h1F);
        rd(16'hFF81); chk("R10 hram untouched", cpu_rdata, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_rom();
        t_vram();
        t_xram();
        t_wram();
        t_oam();
        t_hole();
        t_io_hram();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule